// File: doc/BRIEF.md
# Demand-Response Load Shedder with Safe-Swap Handshake

This block drives five appliance relay outputs from a grid emergency input. While no emergency is present every relay is closed (load connected). When the emergency input is high the block disconnects loads. A parameter chooses between two variants. The first sheds all five loads on the first edge at which the emergency is seen. The second waits until the emergency has persisted for a programmable number of cycles, and then disconnects only three loads. The refrigerator and the air-conditioner relays are never opened by this variant.

The block also offers a safe point for replacing its logic while the rest of the system keeps running. A swap request, or a low activity flag from the parent controller, sends the block into an idle state at the next clock edge. In the idle state the relays are frozen. While the block is idle and the request is still high, a permission output is raised. When the request drops and the parent is active, the block resumes normal work on the next edge. In the delayed variant the emergency delay then starts over.

Relay bit order on `relayOn`: bit 0 refrigerator, bit 1 dishwasher, bit 2 freezer, bit 3 air conditioner, bit 4 washing machine. A 1 means the load is connected.

Top module: `load_shedder`

## Requirements
- R1: On a rising edge with `rst` high, the block goes to its normal state. All five `relayOn` bits become 1 and `swapAllow` becomes 0.
- R2: Variant 0 (`VARIANT`=0), at an edge where the block is not going idle: if `emergency` is high, all five relay bits become 0 after that edge. If `emergency` is low, all five become 1.
- R3: Variant 1 never opens the refrigerator (bit 0) or the air-conditioner (bit 3) relay. These bits stay 1 at every cycle outside reset.
- R4: Variant 1 opens bits 1, 2 and 4 after the edge at which `emergency` has been high on `DELAY_CYCLES` consecutive non-idle edges. Before that edge all five bits remain 1. `DELAY_CYCLES` must be at least 2.
- R5: In variant 1, a non-idle edge with `emergency` low closes all relays and restarts the consecutive count from zero.
- R6: An edge with `swapReq` high puts the block into its idle state. `swapAllow` equals "block is idle AND `swapReq` is high", so it drops at once when `swapReq` falls.
- R7: An edge with `parentActive` low also puts the block into its idle state. `swapAllow` stays low unless `swapReq` is high.
- R8: At every edge that enters or keeps the idle state, `relayOn` holds its previous value, whatever `emergency` does.
- R9: The first edge with `swapReq` low and `parentActive` high, after idle, is a normal step as in R2/R4. In variant 1 the consecutive count restarts at that edge, and the relays close if the count is not yet complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| emergency | input | 1 | Grid emergency request, high to shed |
| swapReq | input | 1 | Request to move to the swap-safe idle state |
| parentActive | input | 1 | Activity flag of the parent state; low forces idle |
| relayOn | output | 5 | Relay controls, 1 = load connected (bit order above) |
| swapAllow | output | 1 | High while idle with `swapReq` high |

## Verification
The hardest situation to reach is leaving idle in variant 1 while the emergency is still high. The relays were frozen open, so the resume edge must close them and restart the count. The stimulus first drives a full shed and holds the emergency high. It then raises the swap request for a few cycles and drops it, with the emergency still high. The relays are watched through the full recount. A long pseudo-random sweep follows, biased toward long emergency runs, with occasional request and parent-inactive pulses. Both variants are compared against an arithmetic reference model built on a consecutive-run counter.

// File: rtl/load_shed_pkg.sv
package load_shed_pkg;
  localparam int NUM_LOADS = 5;
  localparam int IDX_FRIDGE = 0;
  localparam int IDX_DISHWASHER = 1;
  localparam int IDX_FREEZER = 2;
  localparam int IDX_AIRCON = 3;
  localparam int IDX_WASHER = 4;
  localparam logic [NUM_LOADS-1:0] SPARE_MASK =
    NUM_LOADS'((1 << IDX_FRIDGE) | (1 << IDX_AIRCON));

  typedef struct packed {
    logic connectAll;
    logic shed;
  } relayCmd_t;

  typedef enum logic [1:0] {
    ST_CONN  = 2'd0,
    ST_DELAY = 2'd1,
    ST_SHED  = 2'd2,
    ST_IDLE  = 2'd3
  } shedState_t;
endpackage

// File: rtl/shed_ctrl.sv
module shed_ctrl
  import load_shed_pkg::*;
#(
  parameter int VARIANT = 1,
  parameter int DELAY_CYCLES = 6
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      emergency,
  input  logic      swapReq,
  input  logic      parentActive,
  output relayCmd_t cmd,
  output logic      idleNow
);
  localparam int CW = $clog2(DELAY_CYCLES + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(DELAY_CYCLES - 1);

  shedState_t stateQ, nextState, effState;
  logic [CW-1:0] cntQ, nextCnt;

  always_comb begin
    nextState = stateQ;
    nextCnt = cntQ;
    cmd = '0;
    effState = (stateQ == ST_IDLE) ? ST_CONN : stateQ;
    if (swapReq || !parentActive) begin
      nextState = ST_IDLE;
      nextCnt = '0;
    end else if (VARIANT == 0) begin
      nextCnt = '0;
      if (emergency) begin
        cmd.shed = 1'b1;
        nextState = ST_SHED;
      end else begin
        cmd.connectAll = 1'b1;
        nextState = ST_CONN;
      end
    end else if (!emergency) begin
      cmd.connectAll = 1'b1;
      nextState = ST_CONN;
      nextCnt = '0;
    end else begin
      case (effState)
        ST_CONN: begin
          cmd.connectAll = 1'b1;
          nextState = ST_DELAY;
          nextCnt = CW'(1);
        end
        ST_DELAY: begin
          if (cntQ == LAST_CNT) begin
            cmd.shed = 1'b1;
            nextState = ST_SHED;
            nextCnt = '0;
          end else begin
            nextCnt = cntQ + CW'(1);
          end
        end
        default: begin
          cmd.shed = 1'b1;
          nextState = ST_SHED;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= ST_CONN;
      cntQ <= '0;
    end else begin
      stateQ <= nextState;
      cntQ <= nextCnt;
    end
  end

  assign idleNow = (stateQ == ST_IDLE);

  // R4: the delay counter never runs past its window
  a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
    cntQ < CW'(DELAY_CYCLES));

  // R6: a request seen at the previous edge leaves the machine idle
  a_r6_idle_after_req: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(swapReq)) |-> idleNow);

  // R7: an inactive parent at the previous edge leaves the machine idle
  a_r7_idle_parent: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(parentActive)) |-> idleNow);
endmodule

// File: rtl/shed_relays.sv
module shed_relays
  import load_shed_pkg::*;
#(
  parameter int VARIANT = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  relayCmd_t            cmd,
  output logic [NUM_LOADS-1:0] relayOn
);
  logic [NUM_LOADS-1:0] shedPattern;

  generate
    if (VARIANT == 0) begin : g_full_shed
      assign shedPattern = '0;
    end else begin : g_selective_shed
      assign shedPattern = SPARE_MASK;
      // R3: spared loads stay connected in the selective variant
      a_r3_spared_on: assert property (@(posedge clk) disable iff (rst)
        relayOn[IDX_FRIDGE] && relayOn[IDX_AIRCON]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      relayOn <= '1;
    end else if (cmd.connectAll) begin
      relayOn <= '1;
    end else if (cmd.shed) begin
      relayOn <= shedPattern;
    end
  end

  // R2/R4: the control never asks for both actions at once
  a_r2_cmd_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd.connectAll, cmd.shed}));

  // R1: reset leaves every load connected
  a_r1_reset_relays: assert property (@(posedge clk)
    $past(rst) |-> (relayOn == '1));
endmodule

// File: rtl/load_shedder.sv
module load_shedder
  import load_shed_pkg::*;
#(
  parameter int VARIANT = 1,
  parameter int DELAY_CYCLES = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       emergency,
  input  logic       swapReq,
  input  logic       parentActive,
  output logic [4:0] relayOn,
  output logic       swapAllow
);
  relayCmd_t cmd;
  logic idleNow;

  shed_ctrl #(.VARIANT(VARIANT), .DELAY_CYCLES(DELAY_CYCLES)) u_ctrl (
    .clk(clk), .rst(rst), .emergency(emergency), .swapReq(swapReq),
    .parentActive(parentActive), .cmd(cmd), .idleNow(idleNow)
  );

  shed_relays #(.VARIANT(VARIANT)) u_relays (
    .clk(clk), .rst(rst), .cmd(cmd), .relayOn(relayOn)
  );

  assign swapAllow = idleNow && swapReq;

  // R8: an edge that enters or keeps idle leaves the relays untouched
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(swapReq) || !$past(parentActive))) |-> $stable(relayOn));

  // R1: permission is low right after reset
  a_r1_reset_allow: assert property (@(posedge clk)
    $past(rst) |-> !swapAllow);

  generate
    if (VARIANT == 0) begin : g_v0_check
      // R2: an emergency on a normal edge opens every relay
      a_r2_full_shed: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(emergency && !swapReq && parentActive)) |-> (relayOn == '0));
    end
  endgenerate
endmodule

// File: tb/sim_load_shedder.sv
module sim_load_shedder;
  localparam int DLY = 4;
  localparam logic [4:0] SHED1 = 5'b01001;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic emergency = 1'b0;
  logic swapReq = 1'b0;
  logic parentActive = 1'b1;
  logic [4:0] relay0, relay1;
  logic allow0, allow1;

  int total = 0;
  int bad = 0;

  logic [4:0] exp0, exp1;
  logic expIdle;
  int runLen;

  always #10 clk = ~clk;

  load_shedder #(.VARIANT(0), .DELAY_CYCLES(DLY)) u0 (
    .clk(clk), .rst(rst), .emergency(emergency), .swapReq(swapReq),
    .parentActive(parentActive), .relayOn(relay0), .swapAllow(allow0)
  );

  load_shedder #(.VARIANT(1), .DELAY_CYCLES(DLY)) u1 (
    .clk(clk), .rst(rst), .emergency(emergency), .swapReq(swapReq),
    .parentActive(parentActive), .relayOn(relay1), .swapAllow(allow1)
  );

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, expv, $time);
    end
  endtask

  // advance one edge, update the reference, check at the next falling edge
  task automatic step(input string tag0, input string tag1);
    @(posedge clk);
    if (rst) begin
      exp0 = 5'b11111; exp1 = 5'b11111; expIdle = 1'b0; runLen = 0;
    end else if (swapReq || !parentActive) begin
      expIdle = 1'b1; runLen = 0;
    end else begin
      expIdle = 1'b0;
      runLen = emergency ? runLen + 1 : 0;
      exp0 = emergency ? 5'b00000 : 5'b11111;
      exp1 = (runLen >= DLY) ? SHED1 : 5'b11111;
    end
    @(negedge clk);
    check(tag0, relay0, exp0);
    check(tag1, relay1, exp1);
    check("R6 allow0", {4'b0, allow0}, {4'b0, expIdle && swapReq});
    check("R6 allow1", {4'b0, allow1}, {4'b0, expIdle && swapReq});
    if (!rst) check("R3 spared", {3'b0, relay1[3], relay1[0]}, 5'b00011);
  endtask

  initial begin
    #(20 * 20000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    exp0 = '1; exp1 = '1; expIdle = 1'b0; runLen = 0;
    @(negedge clk);
    step("R1 v0", "R1 v1");
    step("R1 v0", "R1 v1");
    rst = 1'b0;
    check("R1 v0 relays", relay0, 5'b11111);
    check("R1 v1 relays", relay1, 5'b11111);
    check("R1 allow", {3'b0, allow1, allow0}, 5'b0);

    // R2 / R4: emergency held, then released
    emergency = 1'b1;
    for (int i = 0; i < DLY + 2; i++) step("R2 shed", "R4 delay");
    emergency = 1'b0;
    for (int i = 0; i < 2; i++) step("R2 restore", "R5 restore");

    // R5: a gap one cycle short of expiry restarts the count
    emergency = 1'b1;
    for (int i = 0; i < DLY - 1; i++) step("R2 shed", "R5 prefix");
    emergency = 1'b0;
    step("R2 restore", "R5 gap");
    emergency = 1'b1;
    for (int i = 0; i < DLY + 1; i++) step("R2 shed", "R5 recount");

    // R6 / R8 / R9: request while shed, emergency still high
    swapReq = 1'b1;
    for (int i = 0; i < 3; i++) step("R8 v0 hold", "R8 v1 hold");
    swapReq = 1'b0;
    #1;
    check("R6 allow drops", {3'b0, allow1, allow0}, 5'b0);
    for (int i = 0; i < DLY + 1; i++) step("R9 v0 resume", "R9 v1 recount");

    // R7 / R8: parent inactive with emergency toggling
    parentActive = 1'b0;
    for (int i = 0; i < 4; i++) begin
      emergency = i[0];
      step("R7 v0 hold", "R7 v1 hold");
    end
    parentActive = 1'b1;
    emergency = 1'b0;
    step("R9 v0 resume", "R9 v1 resume");

    // sweep: long emergency runs with sparse idle pulses
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      emergency = lfsr[0] | lfsr[1] | lfsr[2];
      swapReq = (lfsr[5:3] == 3'd0) && lfsr[9];
      parentActive = !((lfsr[8:6] == 3'd0) && lfsr[11]);
      step("R2 sweep", "R4 sweep");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule